// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block is the timekeeping core of a real-time clock. It keeps the time of day and the calendar date as seven packed BCD register bytes: seconds, minutes, hours, weekday, day of month, month and two-digit year. A free-running prescaler elsewhere on the chip delivers one-cycle `tick_i` pulses. After `SUBDIV` of those pulses the calendar advances by one second. The carry then ripples through minutes, hours, weekday, day of month, month and year, all in the same clock cycle.

Each byte keeps a fixed layout, and the counters update their BCD digits inside it. The seconds byte also carries a halt flag that freezes the clock. The hours byte holds a 12/24-hour mode select and a PM flag next to the hour digits. A single byte-wide write port can load any register. A combinational read port returns any register in its stored form. Reserved bits are cleared on write. Written values are not checked for BCD legality.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the registers read as follows: seconds 0x00 (running), minutes 0x00, hours 0x00 (24-hour mode), weekday 0x01, day of month 0x01, month 0x01, year 0x00. The register addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year. Address 7 always reads 0x00.
- R2: A write stores the data byte ANDed with a per-register mask, and a later read returns that value. The masks are: seconds 0xFF, minutes 0x7F, hours 0x7F, weekday 0x07, day of month 0x3F, month 0x1F, year 0xFF. A write to address 7 changes nothing.
- R3: The seconds value advances by one on every `SUBDIV`-th accepted tick pulse. While seconds bit 7 (halt) is 1, ticks change neither the registers nor the sub-second phase.
- R4: Seconds (bits 6:0) count 00 to 59, and 59 wraps to 00 with a carry into minutes. Minutes count 00 to 59, and 59 wraps to 00 with a carry into hours.
- R5: In 24-hour mode (hours bit 6 = 0), bits 5:0 count 00 to 23. The wrap from 23 to 00 advances the day.
- R6: In 12-hour mode (hours bit 6 = 1), bit 5 is the PM flag (1 = PM) and bits 4:0 count 01 to 12. Going from 11 to 12 toggles the flag, and 12 goes to 01. The step from 11 PM to 12 AM advances the day.
- R7: A day advance moves the weekday from 7 to 1 (otherwise up by one). The day of month rolls to 01 after the month's last day: 30 for months 04, 06, 09 and 11, 31 for the other months except February, and for February 29 when the year value is a multiple of 4, else 28. The rollover carries into the month.
- R8: The month goes from 12 to 01 and carries into the year. The year wraps from 99 to 00.
- R9: A write that hits a register takes priority over a tick in the same cycle, and that tick is discarded. A write to seconds also clears the sub-second phase.
- R10: With no write and no tick, all registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle timebase pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |

## Verification
The bench builds the core with `SUBDIV` = 4, so the sub-second phase can be seen through its effects. Three ticks leave the clock unchanged and the fourth advances it. A tick that collides with a write is lost and the second arrives one tick later. A seconds write made partway through a phase restarts the count of four. Writes preload the registers just short of each rollover, so every carry path can be reached in a few cycles: minute, hour, both 12-hour transitions, each month length, leap and common February, and the year wrap.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NREG      = 7;
    localparam int IDX_SEC   = 0;
    localparam int IDX_MIN   = 1;
    localparam int IDX_HOUR  = 2;
    localparam int IDX_WDAY  = 3;
    localparam int IDX_DATE  = 4;
    localparam int IDX_MONTH = 5;
    localparam int IDX_YEAR  = 6;

    // Increment a packed two-digit BCD value (no legality check).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return v + 8'd1;
    endfunction

    // Bits kept when software loads a register.
    function automatic logic [7:0] write_mask(input logic [2:0] idx);
        case (idx)
            3'd0:    return 8'hFF;
            3'd1:    return 8'h7F;
            3'd2:    return 8'h7F;
            3'd3:    return 8'h07;
            3'd4:    return 8'h3F;
            3'd5:    return 8'h1F;
            3'd6:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    // Bits that take part in counting (halt flag excluded).
    function automatic logic [7:0] count_mask(input logic [2:0] idx);
        return (idx == 3'd0) ? 8'h7F : write_mask(idx);
    endfunction

    function automatic logic [7:0] reset_val(input logic [2:0] idx);
        case (idx)
            3'd3, 3'd4, 3'd5: return 8'h01;
            default:          return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] field_lo(input logic [2:0] idx);
        case (idx)
            3'd3, 3'd4, 3'd5: return 8'h01;
            default:          return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] field_hi(input logic [2:0] idx);
        case (idx)
            3'd0, 3'd1: return 8'h59;
            3'd3:       return 8'h07;
            3'd4:       return 8'h31;
            3'd5:       return 8'h12;
            default:    return 8'h99;
        endcase
    endfunction

endpackage

// File: rtl/rtc_bcd_wrap.sv
module rtc_bcd_wrap (
    input  logic [7:0] cur_i,
    input  logic [7:0] lo_i,
    input  logic [7:0] hi_i,
    input  logic       step_i,
    output logic [7:0] nxt_o,
    output logic       wrap_o
);
    import rtc_cal_pkg::*;

    logic at_top;

    assign at_top = (cur_i == hi_i);

    always_comb begin
        nxt_o  = cur_i;
        wrap_o = 1'b0;
        if (step_i) begin
            if (at_top) begin
                nxt_o  = lo_i;
                wrap_o = 1'b1;
            end else begin
                nxt_o  = bcd_inc(cur_i);
            end
        end
    end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
    input  logic [6:0] cur_i,
    input  logic       step_i,
    output logic [6:0] nxt_o,
    output logic       day_o
);
    import rtc_cal_pkg::*;

    logic       mode12;
    logic       pm;
    logic [5:0] inc24;
    logic [4:0] inc12;

    assign mode12 = cur_i[6];
    assign pm     = cur_i[5];
    assign inc24  = 6'(bcd_inc({2'b00, cur_i[5:0]}));
    assign inc12  = 5'(bcd_inc({3'b000, cur_i[4:0]}));

    always_comb begin
        nxt_o = cur_i;
        day_o = 1'b0;
        if (step_i) begin
            if (!mode12) begin
                if (cur_i[5:0] == 6'h23) begin
                    nxt_o = 7'h00;
                    day_o = 1'b1;
                end else begin
                    nxt_o = {1'b0, inc24};
                end
            end else begin
                unique case (cur_i[4:0])
                    5'h11: begin
                        nxt_o = {1'b1, ~pm, 5'h12};
                        day_o = pm;
                    end
                    5'h12:   nxt_o = {1'b1, pm, 5'h01};
                    default: nxt_o = {1'b1, pm, inc12};
                endcase
            end
        end
    end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
    input  logic [4:0] month_i,
    input  logic [4:0] year_i,
    output logic [7:0] last_o
);
    logic leap;

    // Decimal value divisible by 4: even tens with units 0/4/8, odd tens with units 2/6.
    assign leap = year_i[4] ? (year_i[3:0] == 4'd2 || year_i[3:0] == 4'd6)
                            : (year_i[3:0] == 4'd0 || year_i[3:0] == 4'd4 ||
                               year_i[3:0] == 4'd8);

    always_comb begin
        unique case (month_i)
            5'h02:                      last_o = leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_o = 8'h30;
            default:                    last_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core #(
    parameter int SUBDIV = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [2:0] wr_addr_i,
    input  logic [7:0] wr_data_i,
    input  logic [2:0] rd_addr_i,
    output logic [7:0] rd_data_o
);
    import rtc_cal_pkg::*;

    localparam int PW = (SUBDIV > 1) ? $clog2(SUBDIV) : 1;

    logic [7:0]    rf_q     [NREG];
    logic [7:0]    fld_nxt  [NREG];
    logic [NREG-1:0] fld_en;
    logic [NREG-1:0] fld_wrap;
    logic [PW-1:0] phase_q;
    logic          phase_last;
    logic          halted;
    logic          wr_hit;
    logic          step;
    logic [7:0]    last_date;
    logic          unused_wrap;

    assign halted     = rf_q[IDX_SEC][7];
    assign wr_hit     = wr_en_i && (wr_addr_i < 3'(NREG));
    assign phase_last = (phase_q == PW'(SUBDIV - 1));
    assign step       = tick_i && !wr_hit && !halted && phase_last;

    // Carry chain: each field steps when its lower neighbour wraps.
    assign fld_en[IDX_SEC]   = step;
    assign fld_en[IDX_MIN]   = fld_wrap[IDX_SEC];
    assign fld_en[IDX_HOUR]  = fld_wrap[IDX_MIN];
    assign fld_en[IDX_WDAY]  = fld_wrap[IDX_HOUR];
    assign fld_en[IDX_DATE]  = fld_wrap[IDX_HOUR];
    assign fld_en[IDX_MONTH] = fld_wrap[IDX_DATE];
    assign fld_en[IDX_YEAR]  = fld_wrap[IDX_MONTH];
    assign unused_wrap       = fld_wrap[IDX_WDAY] ^ fld_wrap[IDX_YEAR];

    rtc_month_len u_mlen (
        .month_i (rf_q[IDX_MONTH][4:0]),
        .year_i  (rf_q[IDX_YEAR][4:0]),
        .last_o  (last_date)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_fld
        if (g == IDX_HOUR) begin : g_hour
            logic [6:0] hr_nxt;
            rtc_hour_step u_hour (
                .cur_i  (rf_q[g][6:0]),
                .step_i (fld_en[g]),
                .nxt_o  (hr_nxt),
                .day_o  (fld_wrap[g])
            );
            assign fld_nxt[g] = {1'b0, hr_nxt};
        end else if (g == IDX_DATE) begin : g_date
            rtc_bcd_wrap u_cnt (
                .cur_i  (rf_q[g] & count_mask(3'(g))),
                .lo_i   (field_lo(3'(g))),
                .hi_i   (last_date),
                .step_i (fld_en[g]),
                .nxt_o  (fld_nxt[g]),
                .wrap_o (fld_wrap[g])
            );
        end else begin : g_plain
            rtc_bcd_wrap u_cnt (
                .cur_i  (rf_q[g] & count_mask(3'(g))),
                .lo_i   (field_lo(3'(g))),
                .hi_i   (field_hi(3'(g))),
                .step_i (fld_en[g]),
                .nxt_o  (fld_nxt[g]),
                .wrap_o (fld_wrap[g])
            );
        end
    end

    // State register process: write beats tick, halt freezes everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
            for (int i = 0; i < NREG; i++)
                rf_q[i] <= reset_val(3'(i));
        end else if (wr_hit) begin
            rf_q[wr_addr_i] <= wr_data_i & write_mask(wr_addr_i);
            if (wr_addr_i == 3'(IDX_SEC))
                phase_q <= '0;
        end else if (tick_i && !halted) begin
            phase_q <= phase_last ? '0 : phase_q + PW'(1);
            if (phase_last) begin
                for (int i = 0; i < NREG; i++)
                    rf_q[i] <= fld_nxt[i] & count_mask(3'(i));
            end
        end
    end

    // Output process: read mux.
    always_comb begin
        if (rd_addr_i < 3'(NREG))
            rd_data_o = rf_q[rd_addr_i];
        else
            rd_data_o = 8'h00;
    end
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_i,
    input logic       wr_en_i,
    input logic [2:0] wr_addr_i,
    input logic [7:0] wr_data_i,
    input logic [7:0] sec_q,
    input logic [7:0] min_q,
    input logic [7:0] hour_q,
    input logic [7:0] wday_q,
    input logic [7:0] date_q,
    input logic [7:0] mon_q,
    input logic [7:0] year_q
);
    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (min_q[7] == 1'b0 && hour_q[7] == 1'b0 && wday_q[7:3] == 5'd0 &&
         date_q[7:6] == 2'd0 && mon_q[7:5] == 3'd0));

    assert_year_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 3'd6) |=> (year_q == $past(wr_data_i)));

    assert_sec_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_addr_i == 3'd0) |=> (sec_q == $past(wr_data_i)));

    assert_halt_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_q[7] && !wr_en_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) &&
                                    $stable(date_q) && $stable(year_q)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !wr_en_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) &&
                                   $stable(wday_q) && $stable(date_q) && $stable(mon_q) &&
                                   $stable(year_q)));

    assert_min_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && sec_q[6:0] != 7'h59) |=> $stable(min_q));

    assert_hour_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && min_q != 8'h59) |=> $stable(hour_q));

    assert_day_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_i && hour_q[6:0] != 7'h23 && hour_q[6:0] != 7'h71)
            |=> ($stable(date_q) && $stable(wday_q)));
endmodule

bind rtc_calendar_core rtc_calendar_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .sec_q     (rf_q[0]),
    .min_q     (rf_q[1]),
    .hour_q    (rf_q[2]),
    .wday_q    (rf_q[3]),
    .date_q    (rf_q[4]),
    .mon_q     (rf_q[5]),
    .year_q    (rf_q[6])
);

// File: tb/rtc_calendar_core_bench.sv
`timescale 1ns/1ps
module rtc_calendar_core_bench;
    localparam int SUBDIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // Behavioural reference state (decimal values).
    int m_s, m_m, m_h, m_wd, m_dt, m_mo, m_yr, m_phase;
    bit m_halt, m_12, m_pm;

    always #2 clk = ~clk;

    rtc_calendar_core #(.SUBDIV(SUBDIV)) u_rtc_calendar_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data)
    );

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int month_days(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_reset();
        m_s = 0; m_m = 0; m_h = 0; m_wd = 1; m_dt = 1; m_mo = 1; m_yr = 0;
        m_phase = 0; m_halt = 0; m_12 = 0; m_pm = 0;
    endtask

    task automatic model_day();
        m_wd = (m_wd == 7) ? 1 : m_wd + 1;
        m_dt++;
        if (m_dt > month_days(m_mo, m_yr)) begin
            m_dt = 1;
            m_mo++;
            if (m_mo > 12) begin
                m_mo = 1;
                m_yr = (m_yr + 1) % 100;
            end
        end
    endtask

    task automatic model_second();
        m_s++;
        if (m_s < 60) return;
        m_s = 0;
        m_m++;
        if (m_m < 60) return;
        m_m = 0;
        if (!m_12) begin
            m_h++;
            if (m_h == 24) begin m_h = 0; model_day(); end
        end else if (m_h == 11) begin
            m_h = 12;
            m_pm = !m_pm;
            if (!m_pm) model_day();
        end else if (m_h == 12) begin
            m_h = 1;
        end else begin
            m_h++;
        end
    endtask

    task automatic model_cycle(input bit tk, input bit we, input logic [2:0] a, input logic [7:0] d);
        if (we && a < 3'd7) begin
            case (a)
                3'd0: begin m_halt = d[7]; m_s = from_bcd(d & 8'h7F); m_phase = 0; end
                3'd1: m_m = from_bcd(d & 8'h7F);
                3'd2: begin
                    m_12 = d[6];
                    if (m_12) begin m_pm = d[5]; m_h = from_bcd(d & 8'h1F); end
                    else begin m_pm = 0; m_h = from_bcd(d & 8'h3F); end
                end
                3'd3: m_wd = int'(d & 8'h07);
                3'd4: m_dt = from_bcd(d & 8'h3F);
                3'd5: m_mo = from_bcd(d & 8'h1F);
                default: m_yr = from_bcd(d);
            endcase
        end else if (tk && !m_halt) begin
            if (m_phase == SUBDIV - 1) begin
                m_phase = 0;
                model_second();
            end else begin
                m_phase++;
            end
        end
    endtask

    function automatic logic [7:0] expect_byte(input int a);
        case (a)
            0: return (m_halt ? 8'h80 : 8'h00) | to_bcd(m_s);
            1: return to_bcd(m_m);
            2: return m_12 ? (8'h40 | (m_pm ? 8'h20 : 8'h00) | to_bcd(m_h)) : to_bcd(m_h);
            3: return 8'(m_wd);
            4: return to_bcd(m_dt);
            5: return to_bcd(m_mo);
            6: return to_bcd(m_yr);
            default: return 8'h00;
        endcase
    endfunction

    task automatic compare_all();
        for (int a = 0; a < 8; a++) begin
            logic [7:0] exp_v;
            rd_addr = 3'(a);
            #0.05;
            exp_v = expect_byte(a);
            checks++;
            if (rd_data !== exp_v) begin
                errors++;
                $display("FAIL %s addr=%0d actual=%02h expected=%02h", cur_req, a, rd_data, exp_v);
            end
        end
    endtask

    task automatic cyc(input bit tk, input bit we, input logic [2:0] a, input logic [7:0] d);
        tick = tk; wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_cycle(tk, we, a, d);
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        compare_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        cyc(1'b0, 1'b1, a, d);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 3'd0, 8'h00);
    endtask

    task automatic set_date(input logic [7:0] wd, input logic [7:0] dt,
                            input logic [7:0] mo, input logic [7:0] yr);
        wr(3'd3, wd); wr(3'd4, dt); wr(3'd5, mo); wr(3'd6, yr);
    endtask

    task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL %s watchdog expired actual=running expected=finished", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1";
        compare_all();
        cyc(1'b0, 1'b0, 3'd0, 8'h00);

        cur_req = "R2";
        wr(3'd1, 8'hC5);
        wr(3'd3, 8'hFB);
        wr(3'd4, 8'hD5);
        wr(3'd5, 8'hE9);
        wr(3'd2, 8'hA3);
        wr(3'd6, 8'h42);
        wr(3'd7, 8'h55);

        cur_req = "R3";
        set_time(8'h10, 8'h20, 8'h30);
        ticks(3);
        ticks(1);
        ticks(5);
        wr(3'd0, 8'hC0);
        ticks(8);
        wr(3'd0, 8'h40);
        ticks(4);

        cur_req = "R4";
        set_time(8'h05, 8'h59, 8'h59);
        ticks(4);
        set_time(8'h07, 8'h12, 8'h59);
        ticks(4);

        cur_req = "R5";
        set_date(8'h07, 8'h10, 8'h06, 8'h15);
        set_time(8'h23, 8'h59, 8'h59);
        ticks(4);

        cur_req = "R6";
        set_time(8'h51, 8'h59, 8'h59);
        ticks(4);
        set_time(8'h72, 8'h59, 8'h59);
        ticks(4);
        set_time(8'h71, 8'h59, 8'h59);
        ticks(4);
        set_time(8'h49, 8'h59, 8'h59);
        ticks(4);

        cur_req = "R7";
        set_date(8'h02, 8'h30, 8'h04, 8'h21);
        set_time(8'h23, 8'h59, 8'h59);
        ticks(4);
        set_date(8'h03, 8'h31, 8'h01, 8'h21);
        set_time(8'h23, 8'h59, 8'h59);
        ticks(4);
        set_date(8'h04, 8'h28, 8'h02, 8'h23);
        set_time(8'h23, 8'h59, 8'h59);
        ticks(4);
        set_date(8'h05, 8'h28, 8'h02, 8'h24);
        set_time(8'h23, 8'h59, 8'h59);
        ticks(4);
        set_time(8'h23, 8'h59, 8'h59);
        ticks(4);
        set_date(8'h06, 8'h30, 8'h07, 8'h24);
        set_time(8'h23, 8'h59, 8'h59);
        ticks(4);

        cur_req = "R8";
        set_date(8'h01, 8'h31, 8'h12, 8'h99);
        set_time(8'h23, 8'h59, 8'h59);
        ticks(4);
        set_date(8'h01, 8'h31, 8'h12, 8'h41);
        set_time(8'h23, 8'h59, 8'h59);
        ticks(4);

        cur_req = "R9";
        set_time(8'h08, 8'h00, 8'h00);
        ticks(2);
        cyc(1'b1, 1'b1, 3'd1, 8'h33);
        ticks(1);
        ticks(1);
        ticks(3);
        cyc(1'b1, 1'b1, 3'd0, 8'h45);
        ticks(3);
        ticks(1);
        cyc(1'b1, 1'b1, 3'd7, 8'h11);
        ticks(3);

        cur_req = "R10";
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 3'd0, 8'h00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule